// File: doc/BRIEF.md
# Platform Interrupt Controller Target Core

This block gathers 43 level-sensitive interrupt lines and routes them to one interrupt target, such as a processor hart. Software programs a 2-bit priority for every source, an enable bit per source and a 2-bit priority threshold. A gateway per source latches a pending flag while the line is high. A single arbitration path then picks the enabled pending source with the highest priority above the threshold, with ties going to the lowest ID. It drives an interrupt request together with the winner's ID.

The interrupt handler claims the interrupt by reading the claim/complete register. The read returns the winning ID, clears that source's pending flag and marks the source as in service. While a source is in service its gateway ignores the line. The handler ends service by writing the same ID back to the same register. The block also holds a software-interrupt bit for the target. Access is through a simple synchronous register port. Read data is combinational while the read strobe is high, and every side effect takes place at the clock edge that ends the access.

Top module: `plic_core`

## Requirements
- R1: After a synchronous active-high reset, all priorities, enables, the threshold, the pending and in-service flags and the software-interrupt bit are zero. `irq_o` is low and `irq_id_o` is 0.
- R2: The priority of source i is read and written at byte address 4*i, in bits [1:0]. Upper write bits are dropped and read back as zero.
- R3: Pending flags read at 0x1000 (sources 0..31) and 0x1004 (sources 32..42), with source i at bit i mod 32. A pending flag sets one cycle after its line is high, stays set after the line falls, and ignores register writes.
- R4: Enable bits are read and written at 0x2000 and 0x2004, using the same bit layout as the pending flags. A pending source that is not enabled does not raise `irq_o`.
- R5: The threshold is read and written at 0x200000, in bits [1:0]. A source takes part only if its priority is strictly greater than the threshold, so priority 0 never interrupts.
- R6: `irq_o` is high exactly when some source qualifies. `irq_id_o` is the qualifying source with the highest priority, or the lowest ID among equal priorities. It is 0 when none qualifies.
- R7: A read of 0x200004 returns the current winner's ID in bits [5:0], or 0 if there is none. It clears that source's pending flag and puts the source in service, and the gateway ignores the line while the source is in service.
- R8: A write of an ID to 0x200004 (bits [5:0]) ends service for that source. A write naming a source that is not in service has no effect.
- R9: Bit 0 of 0x4000000 drives `swi_o`: writing 1 sets it, writing 0 clears it, and it reads back.
- R10: Source 0 is reserved and never becomes pending, whatever its input line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 43 | Level interrupt lines, bit i is source i |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 32 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_re is high |
| irq_o | output | 1 | Interrupt request to the target |
| irq_id_o | output | 6 | ID of the current winning source |
| swi_o | output | 1 | Software interrupt to the target |

## Verification
Arbitration is tried with four patterns. A lone pending source that is enabled only later separates the enable gating from pending capture. Two sources of equal top priority expose the lowest-ID tie-break. A source whose priority does not exceed the threshold, and a priority-0 source under a zero threshold, separate the strict comparison from a greater-or-equal one. Claim and complete sequences with a matching ID, a mismatched ID and an empty claim show whether the in-service flag masks the gateway and is released only by the correct ID.

// File: rtl/plic_pkg.sv
package plic_pkg;

    localparam int NUM_SRC = 43;
    localparam int PRIO_W  = 2;
    localparam int DATA_W  = 32;

    localparam logic [31:0] PEND_BASE = 32'h0000_1000;
    localparam logic [31:0] EN_BASE   = 32'h0000_2000;
    localparam logic [31:0] THR_ADDR  = 32'h0020_0000;
    localparam logic [31:0] CC_ADDR   = 32'h0020_0004;
    localparam logic [31:0] SWI_ADDR  = 32'h0400_0000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PRIO,
        SEL_PEND,
        SEL_EN,
        SEL_THR,
        SEL_CC,
        SEL_SWI
    } sel_e;

    typedef struct packed {
        sel_e        sel;
        logic [15:0] idx;
    } dec_t;

    function automatic int words_for(input int nsrc);
        return (nsrc + 31) / 32;
    endfunction

    // Map a byte address onto a register group and an index inside it.
    function automatic dec_t decode_addr(input logic [31:0] a, input int nsrc);
        dec_t d;
        logic [31:0] span;
        span  = 32'(words_for(nsrc) * 4);
        d.sel = SEL_NONE;
        d.idx = '0;
        if (a[1:0] == 2'b00) begin
            if (a < 32'(nsrc * 4)) begin
                d.sel = SEL_PRIO;
                d.idx = a[17:2];
            end else if (a >= PEND_BASE && a < PEND_BASE + span) begin
                d.sel = SEL_PEND;
                d.idx = 16'((a - PEND_BASE) >> 2);
            end else if (a >= EN_BASE && a < EN_BASE + span) begin
                d.sel = SEL_EN;
                d.idx = 16'((a - EN_BASE) >> 2);
            end else if (a == THR_ADDR) begin
                d.sel = SEL_THR;
            end else if (a == CC_ADDR) begin
                d.sel = SEL_CC;
            end else if (a == SWI_ADDR) begin
                d.sel = SEL_SWI;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/plic_regs.sv
module plic_regs
    import plic_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int PW   = PRIO_W,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic                     re,
    input  logic [31:0]              addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [NSRC-1:0]          pend,
    input  logic [IW-1:0]            win_id,
    output logic [NSRC-1:0][PW-1:0]  prio_o,
    output logic [NSRC-1:0]          en_o,
    output logic [PW-1:0]            thr_o,
    output logic                     swi_o,
    output logic                     claim_o,
    output logic                     cmpl_o,
    output logic [IW-1:0]            cmpl_id_o,
    output logic [DATA_W-1:0]        rdata
);

    localparam int WORDS = words_for(NSRC);
    localparam int PADW  = WORDS * 32;

    dec_t            dec;
    logic [PADW-1:0] pend_pad;
    logic [PADW-1:0] en_pad;

    assign dec      = decode_addr(addr, NSRC);
    assign pend_pad = PADW'(pend);
    assign en_pad   = PADW'(en_o);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                prio_o[i] <= '0;
                en_o[i]   <= 1'b0;
            end else if (we) begin
                if (dec.sel == SEL_PRIO && dec.idx == 16'(i))
                    prio_o[i] <= wdata[PW-1:0];
                if (dec.sel == SEL_EN && dec.idx == 16'(i / 32))
                    en_o[i] <= wdata[i % 32];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_o <= '0;
            swi_o <= 1'b0;
        end else if (we) begin
            if (dec.sel == SEL_THR) thr_o <= wdata[PW-1:0];
            if (dec.sel == SEL_SWI) swi_o <= wdata[0];
        end
    end

    assign claim_o   = re && (dec.sel == SEL_CC);
    assign cmpl_o    = we && (dec.sel == SEL_CC);
    assign cmpl_id_o = wdata[IW-1:0];

    always_comb begin
        rdata = '0;
        unique case (dec.sel)
            SEL_PRIO: rdata = DATA_W'(prio_o[dec.idx]);
            SEL_PEND: rdata = pend_pad[dec.idx*32 +: 32];
            SEL_EN:   rdata = en_pad[dec.idx*32 +: 32];
            SEL_THR:  rdata = DATA_W'(thr_o);
            SEL_CC:   rdata = DATA_W'(win_id);
            SEL_SWI:  rdata = DATA_W'(swi_o);
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/plic_gateway.sv
module plic_gateway
    import plic_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic            claim,
    input  logic [IW-1:0]   win_id,
    input  logic            cmpl,
    input  logic [IW-1:0]   cmpl_id,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] infl_o
);

    for (genvar i = 0; i < NSRC; i++) begin : g_gw
        localparam logic          LIVE  = (i != 0);
        localparam logic [IW-1:0] MY_ID = IW'(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                pend_o[i] <= 1'b0;
                infl_o[i] <= 1'b0;
            end else if (claim && win_id == MY_ID && pend_o[i]) begin
                pend_o[i] <= 1'b0;
                infl_o[i] <= 1'b1;
            end else begin
                if (src_i[i] && LIVE && !infl_o[i]) pend_o[i] <= 1'b1;
                if (cmpl && cmpl_id == MY_ID)       infl_o[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter
    import plic_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int PW   = PRIO_W,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]         pend,
    input  logic [NSRC-1:0]         en,
    input  logic [NSRC-1:0][PW-1:0] prio,
    input  logic [PW-1:0]           thr,
    output logic                    irq_o,
    output logic [IW-1:0]           id_o
);

    logic [PW-1:0] best_p;

    // The running best starts at the threshold, so the strict compare
    // both enforces the threshold and keeps the lowest ID on a tie.
    always_comb begin
        best_p = thr;
        id_o   = '0;
        irq_o  = 1'b0;
        for (int i = 1; i < NSRC; i++) begin
            if (pend[i] && en[i] && prio[i] > best_p) begin
                best_p = prio[i];
                id_o   = IW'(i);
                irq_o  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/plic_core.sv
module plic_core
    import plic_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int PW   = PRIO_W,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [31:0]       reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic [IW-1:0]     irq_id_o,
    output logic              swi_o
);

    logic [NSRC-1:0][PW-1:0] prio;
    logic [NSRC-1:0]         en;
    logic [NSRC-1:0]         pend;
    logic [NSRC-1:0]         infl;
    logic [PW-1:0]           thr;
    logic                    claim;
    logic                    cmpl;
    logic [IW-1:0]           cmpl_id;

    plic_regs #(.NSRC(NSRC), .PW(PW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .re        (reg_re),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pend      (pend),
        .win_id    (irq_id_o),
        .prio_o    (prio),
        .en_o      (en),
        .thr_o     (thr),
        .swi_o     (swi_o),
        .claim_o   (claim),
        .cmpl_o    (cmpl),
        .cmpl_id_o (cmpl_id),
        .rdata     (reg_rdata)
    );

    plic_gateway #(.NSRC(NSRC)) u_gw (
        .clk     (clk),
        .rst     (rst),
        .src_i   (src_i),
        .claim   (claim),
        .win_id  (irq_id_o),
        .cmpl    (cmpl),
        .cmpl_id (cmpl_id),
        .pend_o  (pend),
        .infl_o  (infl)
    );

    plic_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
        .pend  (pend),
        .en    (en),
        .prio  (prio),
        .thr   (thr),
        .irq_o (irq_o),
        .id_o  (irq_id_o)
    );

endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk
    import plic_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int PW   = PRIO_W,
    localparam int IW  = $clog2(NSRC)
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    irq_o,
    input logic [IW-1:0]           irq_id_o,
    input logic                    swi_o,
    input logic                    reg_we,
    input logic                    reg_re,
    input logic [31:0]             reg_addr,
    input logic                    wbit0,
    input logic [NSRC-1:0]         pend,
    input logic [NSRC-1:0]         infl,
    input logic [NSRC-1:0][PW-1:0] prio,
    input logic [PW-1:0]           thr
);

    AST_IDLE_ID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> irq_id_o == '0); // R6

    AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pend[irq_id_o]); // R6

    AST_WIN_ABOVE_THR: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> prio[irq_id_o] > thr); // R5

    AST_PEND_INFL_EXCL: assert property (@(posedge clk) disable iff (rst)
        (pend & infl) == '0); // R7

    AST_SRC0_QUIET: assert property (@(posedge clk) disable iff (rst)
        !pend[0] && !infl[0]); // R10

    AST_CLAIM_MOVES: assert property (@(posedge clk) disable iff (rst)
        (reg_re && reg_addr == CC_ADDR && irq_o) |=>
            (!pend[$past(irq_id_o)] && infl[$past(irq_id_o)])); // R7

    AST_SWI_WRITE: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == SWI_ADDR) |=> swi_o == $past(wbit0)); // R9

endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .PW(PW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .irq_o    (irq_o),
    .irq_id_o (irq_id_o),
    .swi_o    (swi_o),
    .reg_we   (reg_we),
    .reg_re   (reg_re),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0]),
    .pend     (pend),
    .infl     (infl),
    .prio     (prio),
    .thr      (thr)
);

// File: tb/plic_core_tb.sv
module plic_core_tb;

    localparam int NS = 43;
    localparam logic [31:0] A_PEND0 = 32'h1000;
    localparam logic [31:0] A_PEND1 = 32'h1004;
    localparam logic [31:0] A_EN0   = 32'h2000;
    localparam logic [31:0] A_EN1   = 32'h2004;
    localparam logic [31:0] A_THR   = 32'h200000;
    localparam logic [31:0] A_CC    = 32'h200004;
    localparam logic [31:0] A_SWI   = 32'h4000000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_i = '0;
    logic          reg_we = 1'b0;
    logic          reg_re = 1'b0;
    logic [31:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_o;
    logic [5:0]    irq_id_o;
    logic          swi_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    plic_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src_i),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o),
        .irq_id_o  (irq_id_o),
        .swi_o     (swi_o)
    );

    // Monitor: compares read data against the scoreboard queue.
    always @(negedge clk) begin
        if (reg_re && !rst) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if (reg_rdata !== e) begin
                bad++;
                $display("FAIL %s read 0x%08h: got 0x%08h exp 0x%08h", t, reg_addr, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        reg_re = 1'b1; reg_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    task automatic set_src(input int i, input logic v);
        @(posedge clk); #1;
        src_i[i] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_out(input logic ei, input logic [5:0] eid, input string t);
        @(negedge clk);
        total++;
        if (irq_o !== ei || irq_id_o !== eid) begin
            bad++;
            $display("FAIL %s irq/id: got %0b/%0d exp %0b/%0d", t, irq_o, irq_id_o, ei, eid);
        end
    endtask

    task automatic chk_swi(input logic e, input string t);
        @(negedge clk);
        total++;
        if (swi_o !== e) begin
            bad++;
            $display("FAIL %s swi_o: got %0b exp %0b", t, swi_o, e);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired: got hang exp finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(4);
        @(posedge clk); #1; rst = 1'b0;

        // R1: reset state
        chk_out(1'b0, 6'd0, "R1");
        rd(32'h14, 32'h0, "R1");
        rd(A_PEND0, 32'h0, "R1");
        rd(A_EN0, 32'h0, "R1");
        rd(A_THR, 32'h0, "R1");
        rd(A_CC, 32'h0, "R1");
        rd(A_SWI, 32'h0, "R1");
        chk_swi(1'b0, "R1");

        // R2: priority registers
        wr(32'h14, 32'd3);
        rd(32'h14, 32'd3, "R2");
        wr(32'hA8, 32'hFFFF_FFFF);
        rd(32'hA8, 32'd3, "R2");
        wr(32'hA0, 32'd3);
        wr(32'h1C, 32'd1);
        wr(32'h28, 32'd0);

        // R3: pending capture, hold and write immunity
        set_src(5, 1'b1);
        idle(2);
        rd(A_PEND0, 32'h20, "R3");
        set_src(5, 1'b0);
        idle(2);
        rd(A_PEND0, 32'h20, "R3");
        wr(A_PEND0, 32'h0);
        rd(A_PEND0, 32'h20, "R3");
        chk_out(1'b0, 6'd0, "R4");

        // R4: enables
        wr(A_EN0, 32'h20);
        rd(A_EN0, 32'h20, "R4");
        chk_out(1'b1, 6'd5, "R4");

        // R5: threshold, strict compare
        wr(A_THR, 32'd3);
        rd(A_THR, 32'd3, "R5");
        chk_out(1'b0, 6'd0, "R5");
        wr(A_THR, 32'd2);
        chk_out(1'b1, 6'd5, "R5");

        // R6: equal top priority, lowest ID wins; low-priority source below threshold
        wr(A_EN1, 32'h100);
        wr(A_EN0, 32'hA0);
        set_src(40, 1'b1);
        set_src(7, 1'b1);
        idle(2);
        rd(A_PEND1, 32'h100, "R3");
        chk_out(1'b1, 6'd5, "R6");

        // R7: claim returns winner, clears pending, masks gateway
        rd(A_CC, 32'd5, "R7");
        rd(A_PEND0, 32'h80, "R7");
        chk_out(1'b1, 6'd40, "R7");
        set_src(5, 1'b1);
        idle(2);
        rd(A_PEND0, 32'h80, "R7");

        // R8: mismatched complete ignored, matching complete releases
        wr(A_CC, 32'd6);
        idle(2);
        rd(A_PEND0, 32'h80, "R8");
        wr(A_CC, 32'd5);
        idle(2);
        rd(A_PEND0, 32'hA0, "R8");
        chk_out(1'b1, 6'd5, "R8");

        // R7: drain both, then empty claim returns 0
        set_src(5, 1'b0);
        set_src(40, 1'b0);
        rd(A_CC, 32'd5, "R7");
        rd(A_CC, 32'd40, "R7");
        wr(A_CC, 32'd5);
        wr(A_CC, 32'd40);
        chk_out(1'b0, 6'd0, "R7");
        rd(A_CC, 32'd0, "R7");
        rd(A_PEND1, 32'h0, "R7");
        rd(A_PEND0, 32'h80, "R7");

        // R5: lower threshold admits source 7; priority 0 source never wins
        set_src(10, 1'b1);
        wr(A_EN0, 32'h4A0);
        wr(A_THR, 32'd0);
        chk_out(1'b1, 6'd7, "R5");
        rd(A_CC, 32'd7, "R5");
        chk_out(1'b0, 6'd0, "R5");
        rd(A_PEND0, 32'h400, "R5");

        // R10: source 0 never pends
        wr(A_EN0, 32'h4A1);
        wr(32'h0, 32'd3);
        set_src(0, 1'b1);
        idle(3);
        rd(A_PEND0, 32'h400, "R10");
        chk_out(1'b0, 6'd0, "R10");

        // R9: software interrupt bit
        wr(A_SWI, 32'd1);
        chk_swi(1'b1, "R9");
        rd(A_SWI, 32'd1, "R9");
        wr(A_SWI, 32'd0);
        chk_swi(1'b0, "R9");
        rd(A_SWI, 32'd0, "R9");

        idle(2);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got %0d left exp 0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule